// File: doc/BRIEF.md
# Compact Float Immediate Loader

This block produces a double-precision register value from short 16-bit constants, so a processor can set up floating-point constants without a memory read. It supports two operations. A load takes the 16-bit immediate as the upper half of a single-precision bit pattern, zero-fills the lower half, and widens the result to double. An insert completes a value that an earlier load started. It narrows the current double value to single precision, replaces the low 16 bits of that pattern with the new immediate, and widens the result back to double.

The surrounding pipeline supplies the operation select, the already-assembled immediate and the current register contents. It takes back the result and a one-cycle write strobe. Instruction decoding and the register file are outside this block. No floating-point status is produced or changed.

Top module: `fimm_loader`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `res_we` to 0 and `res_val` to 0 at that edge.
- R2: Each cycle with `req_valid` high produces `res_we` high on the following cycle, with the new `res_val` in that same cycle. A cycle with `req_valid` low gives `res_we` low on the next cycle, and `res_val` keeps its previous value.
- R3: With `req_op` = 0 (load), the single-precision pattern is {`req_imm`, 16 zero bits}. A normal pattern widens with the exponent rebiased by +896 and the fraction left-aligned. Examples: 0x3F80 gives 0x3FF0000000000000, and 0x3FFF gives 0x3FFFE00000000000.
- R4: A load keeps the class of special patterns. 0x0000 and 0x8000 give +0 and -0. 0x7F80 and 0xFF80 give plus and minus infinity. 0x7FC0 gives the quiet NaN 0x7FF8000000000000, with the NaN payload left-aligned.
- R5: A single-precision subnormal pattern is widened to a normalised double: the leading one is removed, the fraction is shifted up and the exponent is adjusted. Example: load 0x0001 gives 0x37A0000000000000.
- R6: With `req_op` = 1 (insert), `cur_val` is narrowed to single precision, bits 15:0 of that pattern are replaced by `req_imm`, and the result is widened. Example: load 0x3F80 followed by insert 0x8000 gives 0x3FF0100000000000.
- R7: When a normal double is narrowed, the fraction bits below single precision are dropped (truncation toward zero).
- R8: A double below the single-precision normal range narrows to a truncated single-precision subnormal. A double below the smallest subnormal, or a double subnormal, narrows to a zero of the same sign. Example: insert 0x0005 into 0x3000000000000000 gives 0x36C4000000000000.
- R9: A finite double at or above 2^128 in magnitude narrows to the largest finite single value of the same sign (pattern 0x7F7FFFFF with sign). Example: insert 0x0000 into 0x47F0000000000000 gives 0x47EFE00000000000.
- R10: A double NaN narrows to single exponent 255 with the top 23 fraction bits. If those bits are all zero, bit 22 is set, so the value stays a NaN. Example: insert 0x0000 into 0x7FF0000000000001 gives 0x7FF8000000000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load, 1 = insert |
| req_imm | input | 16 | Immediate half of a single-precision pattern |
| cur_val | input | 64 | Current double register value (used by insert) |
| res_val | output | 64 | Registered double result |
| res_we | output | 1 | Write strobe, high one cycle after each request |

## Verification
A fault in the narrowing or widening path shows up in `res_val` exactly one cycle after the request that exercises it. A wrong exponent rebias, a lost leading one or a misplaced fraction changes the result word directly. A fault in the output register or strobe shows up as a missing or extra `res_we` pulse, or as `res_val` drifting during idle cycles, again at the next edge. Because the insert path feeds on the previous result, a chained load-then-insert also exposes any loss of precision in the round trip through single precision.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  typedef enum logic {
    OP_LOAD   = 1'b0,
    OP_INSERT = 1'b1
  } fimm_op_e;
endpackage

// File: rtl/fimm_narrow.sv
module fimm_narrow #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [DE+DF:0] dp_in,
  output logic [SE+SF:0] sp_out
);
  localparam int SB         = (1 << (SE - 1)) - 1;
  localparam int DB         = (1 << (DE - 1)) - 1;
  localparam int REBIAS     = DB - SB;
  localparam int NORM_MIN   = REBIAS + 1;
  localparam int DEN_MIN    = REBIAS - SF + 1;
  localparam int OVF_MIN    = DB + SB + 1;
  localparam int SHIFT_BASE = NORM_MIN + DF - SF;

  logic          sgn;
  logic [DE-1:0] ex;
  logic [DF-1:0] fr;
  logic [DF:0]   mant;
  logic [SF-1:0] frac_t;
  int            ev;

  always_comb begin
    sgn    = dp_in[DE+DF];
    ex     = dp_in[DF +: DE];
    fr     = dp_in[DF-1:0];
    mant   = {1'b1, fr};
    ev     = int'(ex);
    frac_t = fr[DF-1 -: SF];
    sp_out = {sgn, {(SE+SF){1'b0}}};
    if (ex == {DE{1'b1}}) begin
      // NaN keeps a nonzero fraction so it cannot collapse to infinity (R10)
      if (fr != '0 && frac_t == '0) frac_t[SF-1] = 1'b1;
      sp_out = {sgn, {SE{1'b1}}, frac_t};
    end else if (ev >= OVF_MIN) begin
      sp_out = {sgn, {(SE-1){1'b1}}, 1'b0, {SF{1'b1}}};
    end else if (ev >= NORM_MIN) begin
      sp_out = {sgn, SE'(ev - REBIAS), frac_t};
    end else if (ev >= DEN_MIN) begin
      sp_out = {sgn, {SE{1'b0}}, SF'(mant >> (SHIFT_BASE - ev))};
    end
  end

  // R9: a finite double input never narrows to an infinity or NaN
  always_comb begin
    if (dp_in[DF +: DE] != {DE{1'b1}})
      a_r9_finite_stays_finite: assert (sp_out[SF +: SE] != {SE{1'b1}});
  end
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic [SE+SF:0] sp_in,
  output logic [DE+DF:0] dp_out
);
  localparam int SB       = (1 << (SE - 1)) - 1;
  localparam int DB       = (1 << (DE - 1)) - 1;
  localparam int REBIAS   = DB - SB;
  localparam int DEN_BASE = REBIAS - SF + 1;
  localparam int PW       = $clog2(SF);
  localparam int PAD      = DF - SF;

  function automatic logic [PW-1:0] lead_one(input logic [SF-1:0] f);
    logic [PW-1:0] pos;
    pos = '0;
    for (int i = 0; i < SF; i++) begin
      if (f[i]) pos = PW'(i);
    end
    return pos;
  endfunction

  logic          s;
  logic [SE-1:0] e;
  logic [SF-1:0] f;
  logic [PW-1:0] p;

  always_comb begin
    s = sp_in[SE+SF];
    e = sp_in[SF +: SE];
    f = sp_in[SF-1:0];
    p = lead_one(f);
    if (e == {SE{1'b1}}) begin
      dp_out = {s, {DE{1'b1}}, f, {PAD{1'b0}}};
    end else if (e == '0 && f == '0) begin
      dp_out = {s, {(DE+DF){1'b0}}};
    end else if (e == '0) begin
      dp_out = {s, DE'(int'(p) + DEN_BASE),
                DF'({f, {PAD{1'b0}}} << (SF - int'(p)))};
    end else begin
      dp_out = {s, DE'(int'(e) + REBIAS), f, {PAD{1'b0}}};
    end
  end

  // R5: a nonzero subnormal single always widens to a normal double
  always_comb begin
    if (sp_in[SF +: SE] == '0 && sp_in[SF-1:0] != '0)
      a_r5_subnormal_normalised: assert (dp_out[DF +: DE] != '0);
  end
endmodule

// File: rtl/fimm_loader.sv
module fimm_loader
  import fimm_pkg::*;
#(
  parameter  int SE    = SP_EXP_W,
  parameter  int SF    = SP_FRAC_W,
  parameter  int DE    = DP_EXP_W,
  parameter  int DF    = DP_FRAC_W,
  localparam int SW    = 1 + SE + SF,
  localparam int DW    = 1 + DE + DF,
  localparam int IMM_W = SW / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_op,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [DW-1:0]    cur_val,
  output logic [DW-1:0]    res_val,
  output logic             res_we
);
  localparam int LOAD_ZERO = DF - SF + IMM_W;
  localparam int INS_ZERO  = DF - SF;

  fimm_op_e      op;
  logic [SW-1:0] sp_narrow;
  logic [SW-1:0] sp_sel;
  logic [DW-1:0] dp_wide;

  assign op = fimm_op_e'(req_op);

  fimm_narrow #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_narrow (
    .dp_in  (cur_val),
    .sp_out (sp_narrow)
  );

  always_comb begin
    if (op == OP_LOAD) begin
      sp_sel = {req_imm, {(SW-IMM_W){1'b0}}};
    end else begin
      sp_sel = sp_narrow;
      sp_sel[IMM_W-1:0] = req_imm;
    end
  end

  fimm_widen #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_widen (
    .sp_in  (sp_sel),
    .dp_out (dp_wide)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_we  <= 1'b0;
      res_val <= '0;
    end else begin
      res_we <= req_valid;
      if (req_valid) res_val <= dp_wide;
    end
  end

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_we);
  a_r2_strobe_drops: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_we);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_val));
  a_r3_load_sign: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_LOAD) |=> res_val[DW-1] == $past(req_imm[IMM_W-1]));
  a_r3_load_low_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_LOAD) |=> res_val[LOAD_ZERO-1:0] == '0);
  a_r6_insert_low_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_INSERT) |=> res_val[INS_ZERO-1:0] == '0);
endmodule

// File: tb/fimm_loader_tb.sv
module fimm_loader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [15:0] req_imm = '0;
  logic [63:0] cur_val = '0;
  logic [63:0] res_val;
  logic        res_we;

  int    n_vec = 0;
  int    n_fail = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_tag = "R2";
  string mdl_tag = "R1";
  logic [63:0] mdl_val = '0;
  logic        mdl_we = 1'b0;
  logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  fimm_loader u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_imm(req_imm), .cur_val(cur_val), .res_val(res_val), .res_we(res_we)
  );

  function automatic logic [63:0] ref_widen(input logic [31:0] s);
    int  e;
    int  f;
    real mag;
    logic [63:0] b;
    e = int'(s[30:23]);
    f = int'(s[22:0]);
    if (e == 255) return {s[31], 11'h7FF, s[22:0], 29'b0};
    if (e == 0 && f == 0) return {s[31], 63'b0};
    if (e == 0) mag = real'(f) * (2.0 ** (-149));
    else        mag = (8388608.0 + real'(f)) * (2.0 ** (e - 150));
    b = $realtobits(mag);
    return {s[31], b[62:0]};
  endfunction

  function automatic logic [31:0] ref_narrow(input logic [63:0] d);
    logic [22:0] f;
    real a;
    real m;
    int  k;
    if (d[62:52] == 11'h7FF) begin
      f = d[51:29];
      if (d[51:0] != 0 && f == 0) f = 23'h400000;
      return {d[63], 8'hFF, f};
    end
    if (d[62:52] == 0) return {d[63], 31'b0};
    a = $bitstoreal({1'b0, d[62:0]});
    if (a >= 2.0 ** 128) return {d[63], 31'h7F7FFFFF};
    if (a >= 2.0 ** (-126)) begin
      k = -126;
      while (a >= 2.0 ** (k + 1)) k++;
      m = $floor(a * (2.0 ** (23 - k)));
      f = 23'(longint'(m) - 64'sd8388608);
      return {d[63], 8'(k + 127), f};
    end
    m = $floor(a * (2.0 ** 149));
    return {d[63], 8'h00, 23'(longint'(m))};
  endfunction

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    logic [31:0] nsp;
    if (rst) begin
      mdl_we  = 1'b0;
      mdl_val = '0;
      mdl_tag = "R1";
    end else begin
      mdl_we = req_valid;
      if (req_valid) begin
        mdl_tag = cur_tag;
        if (req_op) begin
          nsp = ref_narrow(cur_val);
          mdl_val = ref_widen({nsp[31:16], req_imm});
        end else begin
          mdl_val = ref_widen({req_imm, 16'h0000});
        end
      end else begin
        mdl_tag = "R2";
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_vec++;
      if (res_we !== mdl_we || res_val !== mdl_val) begin
        n_fail++;
        $display("FAIL %s: we=%0b val=%h expected we=%0b val=%h",
                 mdl_tag, res_we, res_val, mdl_we, mdl_val);
      end
    end
  end

  task automatic issue(input logic op, input logic [15:0] imm,
                       input logic [63:0] cur, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_imm   = imm;
    cur_val   = cur;
    cur_tag   = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cur_tag   = "R2";
    end
  endtask

  // issue, then compare the registered result one cycle later
  task automatic lit(input logic op, input logic [15:0] imm,
                     input logic [63:0] cur, input logic [63:0] exp_v,
                     input string tag);
    issue(op, imm, cur, tag);
    @(negedge clk);
    req_valid = 1'b0;
    cur_tag   = "R2";
    n_vec++;
    if (res_val !== exp_v || res_we !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: we=%0b val=%h expected we=1 val=%h", tag, res_we, res_val, exp_v);
    end
  endtask

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_we !== 1'b0 || res_val !== 64'h0) begin
      n_fail++;
      $display("FAIL R1: we=%0b val=%h expected we=0 val=0", res_we, res_val);
    end
    rst = 1'b0;
    started = 1;

    lit(1'b0, 16'h3F80, 64'h0, 64'h3FF0000000000000, "R3");
    lit(1'b0, 16'h3FFF, 64'h0, 64'h3FFFE00000000000, "R3");
    lit(1'b0, 16'hBFC0, 64'h0, 64'hBFF8000000000000, "R3");
    lit(1'b0, 16'h0000, 64'h0, 64'h0000000000000000, "R4");
    lit(1'b0, 16'h8000, 64'h0, 64'h8000000000000000, "R4");
    lit(1'b0, 16'h7F80, 64'h0, 64'h7FF0000000000000, "R4");
    lit(1'b0, 16'hFF80, 64'h0, 64'hFFF0000000000000, "R4");
    lit(1'b0, 16'h7FC0, 64'h0, 64'h7FF8000000000000, "R4");
    lit(1'b0, 16'h0001, 64'h0, 64'h37A0000000000000, "R5");
    issue(1'b0, 16'h007F, 64'h0, "R5");
    issue(1'b0, 16'h8040, 64'h0, "R5");
    idle(2);

    // chained load then insert
    issue(1'b0, 16'h3F80, 64'h0, "R6");
    @(negedge clk);
    req_valid = 1'b0;
    lit(1'b1, 16'h8000, mdl_val, 64'h3FF0100000000000, "R6");
    issue(1'b1, 16'h1234, 64'h3FF0123456789ABC, "R7");
    issue(1'b1, 16'hFFFF, 64'hC00FFFFFFFFFFFFF, "R7");
    issue(1'b1, 16'h0000, 64'h37D0000000000000, "R8");
    lit(1'b1, 16'h0005, 64'h3000000000000000, 64'h36C4000000000000, "R8");
    lit(1'b1, 16'h0001, 64'h8000000000000001, 64'h8000000000000000 | 64'h36A0000000000000, "R8");
    lit(1'b1, 16'h0000, 64'h47F0000000000000, 64'h47EFE00000000000, "R9");
    lit(1'b1, 16'h0000, 64'hC7F0000000000000, 64'hC7EFE00000000000, "R9");
    lit(1'b1, 16'h0000, 64'h7FF0000000000001, 64'h7FF8000000000000, "R10");
    issue(1'b1, 16'hABCD, 64'h7FF4000000000000, "R10");
    idle(3);

    for (int i = 0; i < 80; i++) begin
      step_lfsr();
      if (lfsr[0]) begin
        issue(1'b1, lfsr[31:16], lfsr[1] ? mdl_val : lfsr, "R6");
      end else begin
        issue(1'b0, lfsr[47:32], 64'h0, "R3");
      end
      if (lfsr[5:4] == 2'b00) idle(1);
    end
    idle(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule